// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces a slowly sweeping, signed frequency-offset word that drives the modulation input of a clock synthesizer, such as a fractional divider or a digitally controlled oscillator. It runs on the reference clock. The sweep is a symmetric triangle. It moves one offset unit per modulation tick. A prescaler sets the tick rate, and its division ratio is chosen from the two-bit frequency-band select so that the sweep frequency stays roughly the same across input bands.

The total deviation is 1.25% or 3.75%. It can lie entirely below nominal (down spread) or straddle nominal (center spread). An active-low enable gates the modulation. A rising edge on the restart input sends the sweep back to its starting point. Spread, mode and band are captured only when a profile cycle starts. A one-cycle strobe marks each cycle start. The block also provides two pass-through signals: an unmodulated reference copy, and an output-enable for the modulated clock driven from an active-low output-enable pin.

Top module: `ssc_profile_gen`

## Requirements
- R1: While the enable `mod_en_n` is high, and during reset, `offset_o` is 0 from the first clock edge at which the high enable is sampled. The sweep is held at its starting point while disabled.
- R2: One offset unit is 0.005% (50 ppm). The total span is 250 units when `wide_sel`=0 and 750 units when `wide_sel`=1.
- R3: In down spread (`center_sel`=0) the offset covers exactly 0 down to minus the span and is never positive.
- R4: In center spread (`center_sel`=1) the offset covers exactly plus and minus half the span (±125 or ±375).
- R5: The profile starts at its upper extreme and moves downward by one unit per tick. It reverses exactly at each extreme, so one profile cycle lasts twice the span in ticks.
- R6: A tick occurs every DIV_B0, DIV_B1, DIV_B2 or DIV_B3 reference cycles for `band_sel` 00, 01, 10 and 11 (defaults 4, 5, 6 and 8). A profile cycle therefore lasts 2 × span × divider reference cycles.
- R7: A rising edge on `restart` starts a new profile cycle at the upper extreme on the next clock edge. Holding `restart` high causes no further restarts.
- R8: `wide_sel`, `center_sel` and `band_sel` are captured only at a profile-cycle start. A change in the middle of a cycle has no effect until the next start.
- R9: `start_o` is high for exactly one cycle at each profile-cycle start: on enabling, at each wrap, and on each restart. In that cycle `offset_o` equals the upper extreme.
- R10: `ref_o` always equals `ref_i`, whatever the state of the enable.
- R11: `mod_oe_o` is the inverse of `oe_n`. It is deasserted (standing for high impedance) while `oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en_n | input | 1 | Active-low modulation enable |
| wide_sel | input | 1 | Span select: 0 = 1.25%, 1 = 3.75% |
| center_sel | input | 1 | Placement: 0 = down spread, 1 = center spread |
| band_sel | input | 2 | Input frequency band, picks the tick divider |
| restart | input | 1 | Profile restart on rising edge |
| oe_n | input | 1 | Active-low output enable of the modulated clock |
| ref_i | input | 1 | Reference signal to pass through unmodulated |
| offset_o | output | OFS_W (11) | Signed offset in 50 ppm units |
| start_o | output | 1 | One-cycle profile-start strobe |
| ref_o | output | 1 | Unmodulated reference copy |
| mod_oe_o | output | 1 | Modulated-clock output enable |

## Verification
The assertions check four properties on every cycle. The offset never leaves the bounds set by the captured mode and span. Consecutive offsets inside a cycle differ by at most one unit. The strobe always coincides with the upper extreme. A disabled enable forces zero on the following cycle. Only the bench scenarios can show that the extremes are actually reached, that the cycle length matches each band's divider, that a mid-cycle configuration change waits for the wrap, and that a held restart fires only once. The bench does this by comparing each cycle against a timing model built from the elapsed cycles since the last start.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef struct packed {
    logic [1:0] band;
    logic       wide;
    logic       center;
  } ssc_cfg_t;

  function automatic int span_units(logic wide, int narrow_u, int wide_u);
    return wide ? wide_u : narrow_u;
  endfunction

  function automatic int top_value(int span, logic center);
    return center ? span / 2 : 0;
  endfunction

  // distance travelled from the top extreme after pos ticks
  function automatic int fold_pos(int pos, int span);
    return (pos <= span) ? pos : (2 * span - pos);
  endfunction

  function automatic int profile_value(int pos, int span, logic center);
    return top_value(span, center) - fold_pos(pos, span);
  endfunction

endpackage

// File: rtl/ssc_rate_div.sv
module ssc_rate_div #(
  parameter int DIV_B0 = 4,
  parameter int DIV_B1 = 5,
  parameter int DIV_B2 = 6,
  parameter int DIV_B3 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] band,
  output logic       tick
);
  localparam int MAX01 = (DIV_B0 > DIV_B1) ? DIV_B0 : DIV_B1;
  localparam int MAX23 = (DIV_B2 > DIV_B3) ? DIV_B2 : DIV_B3;
  localparam int MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W = $clog2(MAXD + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    case (band)
      2'd0:    lim_m1 = CNT_W'(DIV_B0 - 1);
      2'd1:    lim_m1 = CNT_W'(DIV_B1 - 1);
      2'd2:    lim_m1 = CNT_W'(DIV_B2 - 1);
      default: lim_m1 = CNT_W'(DIV_B3 - 1);
    endcase
  end

  assign tick = (cnt == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R6: the prescaler never runs past the selected band's divider
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= lim_m1));

endmodule

// File: rtl/ssc_sweep_ctrl.sv
module ssc_sweep_ctrl
  import ssc_pkg::*;
#(
  parameter int NARROW_U = 250,
  parameter int WIDE_U   = 750,
  localparam int POS_W   = $clog2(2 * WIDE_U)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             restart,
  input  logic             tick,
  input  ssc_cfg_t         cfg_in,
  output logic             en_q,
  output ssc_cfg_t         cfg_q,
  output logic [POS_W-1:0] pos,
  output logic             start_w,
  output logic             strobe
);
  logic rs_q;
  logic rise_w;
  logic wrap_w;
  int   span_cur;

  assign span_cur = span_units(cfg_q.wide, NARROW_U, WIDE_U);
  assign rise_w   = restart & ~rs_q;
  assign wrap_w   = en_q & tick & (pos == POS_W'(2 * span_cur - 1));
  assign start_w  = ~en_q | rise_w | wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rs_q   <= 1'b0;
      strobe <= 1'b0;
      pos    <= '0;
      cfg_q  <= '0;
    end else begin
      en_q   <= en_req;
      rs_q   <= restart;
      strobe <= en_req & start_w;
      if (start_w) begin
        pos   <= '0;
        cfg_q <= cfg_in;
      end else if (tick) begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R8: captured configuration holds for the whole cycle
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !start_w) |=> $stable(cfg_q));

  // R7: a restart edge while running lands at the cycle start next edge
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && en_q && en_req) |=> (strobe && pos == '0));

  // R5: position never runs past the end of the triangle
  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos) < 2 * span_cur));

endmodule

// File: rtl/ssc_offset_map.sv
module ssc_offset_map
  import ssc_pkg::*;
#(
  parameter int NARROW_U = 250,
  parameter int WIDE_U   = 750,
  parameter int OFS_W    = 11,
  localparam int POS_W   = $clog2(2 * WIDE_U)
) (
  input  logic                    en_q,
  input  ssc_cfg_t                cfg,
  input  logic [POS_W-1:0]        pos,
  output logic signed [OFS_W-1:0] offset
);
  int span_w;

  assign span_w = span_units(cfg.wide, NARROW_U, WIDE_U);

  always_comb begin
    if (en_q) offset = OFS_W'(profile_value(int'(pos), span_w, cfg.center));
    else      offset = '0;
  end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int NARROW_U = 250,
  parameter int WIDE_U   = 750,
  parameter int OFS_W    = 11,
  parameter int DIV_B0   = 4,
  parameter int DIV_B1   = 5,
  parameter int DIV_B2   = 6,
  parameter int DIV_B3   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en_n,
  input  logic                    wide_sel,
  input  logic                    center_sel,
  input  logic [1:0]              band_sel,
  input  logic                    restart,
  input  logic                    oe_n,
  input  logic                    ref_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    start_o,
  output logic                    ref_o,
  output logic                    mod_oe_o
);
  localparam int POS_W = $clog2(2 * WIDE_U);

  ssc_cfg_t         cfg_in;
  ssc_cfg_t         cfg_q;
  logic             en_q;
  logic             tick_w;
  logic             start_w;
  logic [POS_W-1:0] pos;
  int               span_w;
  int               top_w;

  assign cfg_in = '{band: band_sel, wide: wide_sel, center: center_sel};

  ssc_rate_div #(
    .DIV_B0(DIV_B0), .DIV_B1(DIV_B1), .DIV_B2(DIV_B2), .DIV_B3(DIV_B3)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .clear(start_w), .band(cfg_q.band), .tick(tick_w)
  );

  ssc_sweep_ctrl #(.NARROW_U(NARROW_U), .WIDE_U(WIDE_U)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_req(~mod_en_n), .restart(restart),
    .tick(tick_w), .cfg_in(cfg_in), .en_q(en_q), .cfg_q(cfg_q), .pos(pos),
    .start_w(start_w), .strobe(start_o)
  );

  ssc_offset_map #(.NARROW_U(NARROW_U), .WIDE_U(WIDE_U), .OFS_W(OFS_W)) u_map (
    .en_q(en_q), .cfg(cfg_q), .pos(pos), .offset(offset_o)
  );

  assign ref_o    = ref_i;
  assign mod_oe_o = ~oe_n;

  assign span_w = span_units(cfg_q.wide, NARROW_U, WIDE_U);
  assign top_w  = top_value(span_w, cfg_q.center);

  // R1: a high enable zeroes the offset on the next edge
  p_zero_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en_n |=> (offset_o == '0));

  // R3: down spread stays at or below nominal, within the span
  p_down_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cfg_q.center) |-> ($signed(offset_o) <= 0 && $signed(offset_o) >= -span_w));

  // R4: center spread stays within half the span either side
  p_center_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_q.center) |-> ($signed(offset_o) <= span_w / 2 && $signed(offset_o) >= -(span_w / 2)));

  // R5: inside a cycle the offset moves at most one unit per clock
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mod_en_n && !start_w) |=>
      (offset_o == $past(offset_o) || offset_o == $past(offset_o) + 1'b1 ||
       offset_o == $past(offset_o) - 1'b1));

  // R9: the start strobe coincides with the upper extreme
  p_strobe_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($signed(offset_o) == top_w));

endmodule

// File: tb/tb_ssc_profile_gen.sv
module tb_ssc_profile_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en_n = 1'b1, wide_sel = 1'b0, center_sel = 1'b0, restart = 1'b0;
  logic oe_n = 1'b0, ref_i = 1'b0;
  logic [1:0] band_sel = 2'd0;
  logic signed [10:0] offset_o;
  logic start_o, ref_o, mod_oe_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string off_tag = "R5";
  // bench timing model
  bit m_en = 0, m_rs = 0, cw = 0, cc = 0;
  int cb = 0, m_m = 0, e_off = 0, minv = 0, maxv = 0;
  bit e_strb = 0;

  always #2.5 clk = ~clk;

  ssc_profile_gen dut (
    .clk(clk), .rst_n(rst_n), .mod_en_n(mod_en_n), .wide_sel(wide_sel),
    .center_sel(center_sel), .band_sel(band_sel), .restart(restart), .oe_n(oe_n),
    .ref_i(ref_i), .offset_o(offset_o), .start_o(start_o), .ref_o(ref_o),
    .mod_oe_o(mod_oe_o)
  );

  function automatic int b_span(bit w);
    return w ? 750 : 250;
  endfunction

  function automatic int b_div(int b);
    case (b)
      0: return 4;
      1: return 5;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  // offset after m cycles since a start: descend first, then climb back
  function automatic int b_expect(int m, bit w, bit c, int b);
    int k, s, d;
    s = b_span(w);
    k = m / b_div(b);
    d = (k <= s) ? k : (2 * s - k);
    return c ? (s / 2 - d) : -d;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit rise, wrap;
    int per, off;
    @(posedge clk);
    rise = restart && !m_rs;
    per  = 2 * b_span(cw) * b_div(cb);
    wrap = m_en && (m_m == per - 1);
    if (!m_en || rise || wrap) begin
      e_strb = !mod_en_n;
      m_m = 0; cw = wide_sel; cc = center_sel; cb = int'(band_sel);
    end else begin
      e_strb = 0;
      m_m++;
    end
    m_en = !mod_en_n;
    m_rs = restart;
    e_off = m_en ? b_expect(m_m, cw, cc, cb) : 0;
    #1;
    off = int'(offset_o);
    chk(off == e_off, off_tag, off, e_off);
    chk(start_o == e_strb, "R9", int'(start_o), int'(e_strb));
    chk(ref_o == ref_i, "R10", int'(ref_o), int'(ref_i));
    chk(mod_oe_o == !oe_n, "R11", int'(mod_oe_o), int'(!oe_n));
    if (m_en && !cc) chk(off <= 0, "R3", off, 0);
    if (m_en && cc)  chk(off <= b_span(cw) / 2 && off >= -(b_span(cw) / 2), "R4", off, b_span(cw) / 2);
    if (off < minv) minv = off;
    if (off > maxv) maxv = off;
    ref_i = 1'($urandom);
    oe_n  = 1'($urandom);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic until_start();
    do step(); while (!start_o);
  endtask

  task automatic finish_up();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(offset_o == 0, "R1", int'(offset_o), 0);
    chk(start_o == 0, "R1", int'(start_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3/R5: narrow down spread
    mod_en_n = 1'b0;
    minv = 0; maxv = -1000;
    run(2010);
    chk(minv == -250, "R2", minv, -250);
    chk(maxv == 0, "R2", maxv, 0);

    // R2/R3: wide down spread
    wide_sel = 1'b1;
    until_start();
    minv = 0; maxv = -1000;
    run(6000);
    chk(minv == -750, "R2", minv, -750);
    chk(maxv == 0, "R3", maxv, 0);

    // R4: wide center spread
    center_sel = 1'b1; band_sel = 2'd1;
    until_start();
    minv = 1000; maxv = -1000;
    run(7500);
    chk(minv == -375, "R4", minv, -375);
    chk(maxv == 375, "R4", maxv, 375);

    // R6: cycle length per band, narrow center
    off_tag = "R6";
    wide_sel = 1'b0;
    for (int b = 0; b < 4; b++) begin
      band_sel = 2'(b);
      until_start();
      cnt = 0;
      do begin step(); cnt++; end while (!start_o);
      chk(cnt == 500 * b_div(b), "R6", cnt, 500 * b_div(b));
    end

    // R8: mid-cycle config change waits for the wrap
    off_tag = "R8";
    center_sel = 1'b0; band_sel = 2'd0;
    until_start();
    run(700);
    wide_sel = 1'b1; center_sel = 1'b1; band_sel = 2'd3;
    run(900);
    until_start();
    chk(int'(offset_o) == 375, "R8", int'(offset_o), 375);

    // R7: restart edge, then held high
    off_tag = "R7";
    run(1234);
    restart = 1'b1;
    step();
    chk(start_o == 1'b1, "R7", int'(start_o), 1);
    chk(int'(offset_o) == 375, "R7", int'(offset_o), 375);
    run(3000);
    restart = 1'b0;
    run(20);

    // R1: disable mid-sweep
    off_tag = "R1";
    run(333);
    mod_en_n = 1'b1;
    step();
    chk(offset_o == 0, "R1", int'(offset_o), 0);
    run(50);
    mod_en_n = 1'b0;
    run(100);

    // random mix
    off_tag = "R5";
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 299) == 0) begin
        wide_sel = 1'($urandom); center_sel = 1'($urandom); band_sel = 2'($urandom);
      end
      if ($urandom_range(0, 699) == 0) restart = ~restart;
      if ($urandom_range(0, 1999) == 0) mod_en_n = ~mod_en_n;
      step();
    end
    finish_up();
  end
endmodule